// File: doc/BRIEF.md
# Operating Mode Controller

This block holds the operating mode of a multi-channel relay-switched source module. The host selects one of four modes (measurement, test, adjustment, idle) by writing a one-hot code to a command register. The block rejects writes that name more than one mode, and it rejects writes that would leave idle for measurement or adjustment before the channels are configured. Each rejection is latched as a mode error that the host can read back. The current mode is driven to neighbouring blocks as a one-hot enable vector.

A front-panel reset push button is synchronised and debounced. A press is accepted only while the module is in idle. An accepted press produces a one-cycle soft reset pulse for the rest of the module and clears the error state. It also raises an active-low interrupt request that stays low until the host acknowledges it. A second active-low interrupt line follows a configuration-fault input.

Top module: `opm_ctrl`

## Requirements
- R1: After rst_ni the command register (offset 0x20) reads 0x0008 (idle), the status (0x22) and status-type (0x24) registers read 0, both interrupt lines are high and soft_rst_o is low.
- R2: A write to 0x20 with exactly one of bits 3:0 set selects that mode: bit 0 measurement, bit 1 test, bit 2 adjustment, bit 3 idle. The change is visible on readback and on mode_o after the write's clock edge. Bits 15:4 of the write data are ignored and read back as 0.
- R3: A write with two or more of bits 3:0 set leaves the mode unchanged. It sets the mode-error flag, which reads as bit 0 of 0x24 and bit 1 of 0x22.
- R4: A write selecting measurement or adjustment while cfg_ready_i is low leaves the mode unchanged and sets the mode-error flag.
- R5: An accepted mode write clears the mode-error flag. A write with bits 3:0 all zero changes neither the mode nor the flag.
- R6: A button level that lasts fewer than DEBOUNCE_CYC clocks after synchronisation is ignored.
- R7: A debounced press while in idle gives exactly one soft_rst_o pulse of one cycle, however long the button is held. The press clears the mode-error flag, keeps the mode at idle and drives btn_irq_no low.
- R8: A press while in measurement, test or adjustment has no effect: no soft_rst_o pulse, btn_irq_no stays high and the mode is unchanged.
- R9: btn_irq_no stays low until irq_ack_i is high on a clock edge, and is high after that edge.
- R10: cfg_irq_no is low one clock after fault_i is high, and high one clock after fault_i is low.
- R11: mode_o always has exactly one bit set and equals bits 3:0 of the command register readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| cfg_ready_i | input | 1 | Channels configured, leaving idle for measurement/adjustment allowed |
| btn_i | input | 1 | Raw push button, high when pressed |
| irq_ack_i | input | 1 | Host acknowledge of the button interrupt |
| fault_i | input | 1 | Configuration fault condition |
| mode_o | output | 4 | One-hot mode enables (0 meas, 1 test, 2 adj, 3 idle) |
| soft_rst_o | output | 1 | One-cycle module soft reset pulse |
| btn_irq_no | output | 1 | Button interrupt request, active low |
| cfg_irq_no | output | 1 | Fault interrupt request, active low |

## Verification
A table walks the command register through single-bit codes, multi-bit codes, an all-zero code and codes with junk in the upper bits, with the configuration-ready input both low and high. This separates mode selection, illegal-combination rejection and the configuration gate, and shows when the error flag is cleared. Directed button stimulus compares a glitch shorter than the debounce window, a long hold in idle and presses in measurement and test mode. These cases expose a missing filter, repeated pulses and gating by the wrong mode. The acknowledge and fault sequences check that each interrupt line is held and released correctly.

// File: rtl/opm_pkg.sv
package opm_pkg;
  localparam int MODE_W = 4;

  typedef enum int {
    M_MEAS = 0,
    M_TEST = 1,
    M_ADJ  = 2,
    M_IDLE = 3
  } mode_idx_e;

  localparam logic [MODE_W-1:0] MODE_IDLE = 4'b1000;

  localparam int OFS_CMD   = 'h20;
  localparam int OFS_STS   = 'h22;
  localparam int OFS_STYPE = 'h24;

  localparam int STS_ERR_BIT        = 1;
  localparam int STYPE_MODE_ERR_BIT = 0;
endpackage

// File: rtl/opm_btn_filter.sv
module opm_btn_filter #(
  parameter int DEBOUNCE_CYC = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   deb_q, deb_prev_q;
  logic                   raw;

  assign raw = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i};
  end

  // level must differ from the filtered state for DEBOUNCE_CYC clocks in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      deb_q <= 1'b0;
    end else if (raw == deb_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      deb_q <= raw;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) deb_prev_q <= 1'b0;
    else         deb_prev_q <= deb_q;
  end

  assign press_o = deb_q & ~deb_prev_q;
endmodule

// File: rtl/opm_mode_reg.sv
module opm_mode_reg
  import opm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] wdata_i,
  input  logic              cfg_ready_i,
  input  logic              soft_clr_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              mode_err_o
);
  logic [MODE_W-1:0] mode_q;
  logic              err_q;
  logic [2:0]        ones;
  logic              legal, needs_cfg, accept, empty;

  always_comb begin
    ones = '0;
    for (int i = 0; i < MODE_W; i++) ones = ones + 3'(wdata_i[i]);
  end

  assign empty     = (wdata_i == '0);
  assign legal     = (ones == 3'd1);
  assign needs_cfg = wdata_i[M_MEAS] | wdata_i[M_ADJ];
  assign accept    = legal & (~needs_cfg | cfg_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      err_q  <= 1'b0;
    end else if (soft_clr_i) begin
      mode_q <= MODE_IDLE;
      err_q  <= 1'b0;
    end else if (wr_i && !empty) begin
      if (accept) begin
        mode_q <= wdata_i;
        err_q  <= 1'b0;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  assign mode_o     = mode_q;
  assign mode_err_o = err_q;
endmodule

// File: rtl/opm_irq.sv
module opm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic fault_i,
  output logic btn_irq_no,
  output logic cfg_irq_no
);
  logic pend_q, fault_q;

  // a new request in the acknowledge cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= fault_i;
  end

  assign btn_irq_no = ~pend_q;
  assign cfg_irq_no = ~fault_q;
endmodule

// File: rtl/opm_ctrl.sv
module opm_ctrl
  import opm_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int DEBOUNCE_CYC = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              cfg_ready_i,
  input  logic              btn_i,
  input  logic              irq_ack_i,
  input  logic              fault_i,
  output logic [3:0]        mode_o,
  output logic              soft_rst_o,
  output logic              btn_irq_no,
  output logic              cfg_irq_no
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_STYPE = ADDR_W'(OFS_STYPE);

  logic              press, accept_press, soft_rst_q, mode_err, cmd_wr;
  logic [MODE_W-1:0] mode;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata_i[DATA_W-1:MODE_W];
  assign cmd_wr    = bus_we_i && (bus_addr_i == A_CMD);

  opm_btn_filter #(
    .DEBOUNCE_CYC(DEBOUNCE_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_btn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (btn_i),
    .press_o(press)
  );

  assign accept_press = press & mode[M_IDLE];

  opm_mode_reg i_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cmd_wr),
    .wdata_i    (bus_wdata_i[MODE_W-1:0]),
    .cfg_ready_i(cfg_ready_i),
    .soft_clr_i (accept_press),
    .mode_o     (mode),
    .mode_err_o (mode_err)
  );

  opm_irq i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (accept_press),
    .ack_i     (irq_ack_i),
    .fault_i   (fault_i),
    .btn_irq_no(btn_irq_no),
    .cfg_irq_no(cfg_irq_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_rst_q <= 1'b0;
    else         soft_rst_q <= accept_press;
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CMD:   bus_rdata_o[MODE_W-1:0]         = mode;
      A_STS:   bus_rdata_o[STS_ERR_BIT]        = mode_err;
      A_STYPE: bus_rdata_o[STYPE_MODE_ERR_BIT] = mode_err;
      default: bus_rdata_o = '0;
    endcase
  end

  assign mode_o     = mode;
  assign soft_rst_o = soft_rst_q;
endmodule

// File: rtl/opm_ctrl_chk.sv
module opm_ctrl_chk
  import opm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [3:0]        mode_o,
  input logic              soft_rst_o,
  input logic              btn_irq_no,
  input logic              irq_ack_i,
  input logic              fault_i,
  input logic              cfg_irq_no
);
  a_r11_onehot_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1);

  a_r3_illegal_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFS_CMD) && $countones(bus_wdata_i[3:0]) > 1)
      |=> $stable(mode_o));

  a_r8_rst_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> mode_o == MODE_IDLE);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  a_r7_irq_with_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> !btn_irq_no);

  a_r9_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!btn_irq_no && !irq_ack_i) |=> !btn_irq_no);

  a_r10_fault_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !cfg_irq_no);
endmodule

bind opm_ctrl opm_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .mode_o     (mode_o),
  .soft_rst_o (soft_rst_o),
  .btn_irq_no (btn_irq_no),
  .irq_ack_i  (irq_ack_i),
  .fault_i    (fault_i),
  .cfg_irq_no (cfg_irq_no)
);

// File: tb/test_opm_ctrl.sv
module test_opm_ctrl;
  localparam int DEB = 8;
  localparam int NV  = 10;
  // {wdata[15:0], cfg_ready, exp_mode[3:0], exp_err}
  localparam logic [21:0] VEC [NV] = '{
    {16'h0002, 1'b0, 4'h2, 1'b0},  // R2 test
    {16'h0001, 1'b0, 4'h2, 1'b1},  // R4 meas blocked
    {16'h0008, 1'b0, 4'h8, 1'b0},  // R5 clear via idle
    {16'h0005, 1'b1, 4'h8, 1'b1},  // R3 two bits
    {16'h0000, 1'b1, 4'h8, 1'b1},  // R5 zero write
    {16'h0001, 1'b1, 4'h1, 1'b0},  // R2 meas
    {16'h0004, 1'b1, 4'h4, 1'b0},  // R2 adj
    {16'hFFF2, 1'b1, 4'h2, 1'b0},  // R2 upper ignored
    {16'h000F, 1'b1, 4'h2, 1'b1},  // R3 all bits
    {16'h0008, 1'b1, 4'h8, 1'b0}   // R5 back to idle
  };

  logic clk = 0, rst_n = 0;
  logic we = 0, cfg_ready = 0, btn = 0, ack = 0, fault = 0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  mode;
  logic        soft_rst, btn_irq_n, cfg_irq_n;
  int checks = 0, failures = 0, pulses = 0, p0;
  bit done = 0;

  always #4 clk = ~clk;

  opm_ctrl #(.DEBOUNCE_CYC(DEB)) i_opm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cfg_ready_i(cfg_ready),
    .btn_i(btn), .irq_ack_i(ack), .fault_i(fault), .mode_o(mode),
    .soft_rst_o(soft_rst), .btn_irq_no(btn_irq_n), .cfg_irq_no(cfg_irq_n));

  always @(posedge clk) if (rst_n && soft_rst) pulses++;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); we = 1; addr = 6'h20; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic press(int hold);
    @(negedge clk); btn = 1;
    repeat (hold) @(negedge clk);
    btn = 0;
    repeat (DEB + 8) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h20, d); check("R1 cmd", d, 16'h0008);
    rd(6'h22, d); check("R1 status", d, 16'h0000);
    rd(6'h24, d); check("R1 stype", d, 16'h0000);
    check("R1 irqs", {14'h0, btn_irq_n, cfg_irq_n}, 16'h0003);
    check("R1 soft_rst", {15'h0, soft_rst}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      cfg_ready = VEC[i][5];
      wr(VEC[i][21:6]);
      rd(6'h20, d); check($sformatf("R2/R3/R4 vec%0d cmd", i), d, {12'h0, VEC[i][4:1]});
      check($sformatf("R11 vec%0d mode_o", i), {12'h0, mode}, {12'h0, VEC[i][4:1]});
      rd(6'h24, d); check($sformatf("R3/R5 vec%0d stype", i), d, {15'h0, VEC[i][0]});
      rd(6'h22, d); check($sformatf("R3 vec%0d status", i), d, {14'h0, VEC[i][0], 1'b0});
    end

    // R6 short glitch
    p0 = pulses;
    press(DEB / 2);
    check("R6 no pulse", 16'(pulses - p0), 16'h0);
    check("R6 irq high", {15'h0, btn_irq_n}, 16'h0001);

    // R7 long press in idle with error pending
    wr(16'h0003);
    p0 = pulses;
    press(DEB * 5);
    check("R7 one pulse", 16'(pulses - p0), 16'h1);
    check("R7 irq low", {15'h0, btn_irq_n}, 16'h0000);
    rd(6'h24, d); check("R7 err cleared", d, 16'h0000);
    rd(6'h20, d); check("R7 idle", d, 16'h0008);

    // R9 hold then acknowledge
    repeat (20) @(negedge clk);
    check("R9 irq held", {15'h0, btn_irq_n}, 16'h0000);
    ack = 1; @(negedge clk); ack = 0;
    check("R9 irq released", {15'h0, btn_irq_n}, 16'h0001);

    // R8 presses outside idle
    cfg_ready = 1;
    wr(16'h0001);
    p0 = pulses;
    press(DEB * 2);
    check("R8 meas no pulse", 16'(pulses - p0), 16'h0);
    check("R8 meas irq high", {15'h0, btn_irq_n}, 16'h0001);
    rd(6'h20, d); check("R8 meas kept", d, 16'h0001);
    wr(16'h0002);
    press(DEB * 2);
    check("R8 test no pulse", 16'(pulses - p0), 16'h0);
    rd(6'h20, d); check("R8 test kept", d, 16'h0002);

    // R10 fault line
    @(negedge clk); fault = 1;
    @(negedge clk); check("R10 fault low", {15'h0, cfg_irq_n}, 16'h0000);
    fault = 0;
    @(negedge clk); check("R10 fault high", {15'h0, cfg_irq_n}, 16'h0001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule